// File: doc/BRIEF.md
# Low-Toggle Scan Pattern Generator

This block is a pseudo-random stimulus source for scan-based logic self-test that keeps the bit switching seen by the scan chains low. A 16-bit maximal-length LFSR drives a bank of per-bit hold stages. The hold stages feed a small XOR spreading network that drives four scan chains. A per-bit gate mask decides which hold stages pass fresh LFSR bits and which keep their last value. The mask is reloaded once per pattern from a side shift register. That shift register's serial input is a weighted random bit made from LFSR bits, and the switch code sets its weight.

A mode flop splits the shift period into burst and freeze intervals. In freeze mode no hold stage updates. In burst mode the stages follow the mask. Each interval ends on a weighted random event. The burst code sets the weight while in burst mode and the freeze code sets it while in freeze mode. A switch code of zero bypasses all of this: every hold stage is transparent. The three 4-bit codes are set before reset is released and stay fixed for the whole session. A strobe marks the last shift cycle of every pattern.

Top module: `lp_pattern_gen`

## Requirements
- R1: The LFSR resets to 0xACE1 and advances each clock as next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. It is never all-zero.
- R2: While rst_ni is low, lfsr_o is 0xACE1, mode_o is 0 and pat_strobe_o is 0. If the switch code is nonzero, latch_o is 0.
- R3: When sw_code_i is 0000, latch_o equals lfsr_o in every cycle.
- R4: When mode_o is 0 (freeze) and sw_code_i is nonzero, latch_o equals its value in the previous cycle.
- R5: When mode_o is 1 (burst), each bit of latch_o either keeps its previous value or equals the same-index bit of lfsr_o.
- R6: scan_o[c] = latch_o[c] ^ latch_o[(c+5)%16] ^ latch_o[(c+11)%16] for c = 0..3.
- R7: pat_strobe_o is high for exactly one cycle in every 32. It is high when the number of clocks since reset release, taken modulo 32, is 31.
- R8: A termination code of 0000 makes the current interval permanent. With frz_code_i = 0 the generator stays in freeze from reset. With brst_code_i = 0, once mode_o is 1 it stays 1.
- R9: The gate mask changes only on the clock edge that ends a pattern. Within one pattern, in burst mode, each latch bit either tracks lfsr_o in every cycle or holds constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_code_i | input | 4 | Weight code for the gate-mask shift register; 0000 disables low-power operation |
| brst_code_i | input | 4 | Weight of the event that ends a burst interval |
| frz_code_i | input | 4 | Weight of the event that ends a freeze interval |
| scan_o | output | 4 | Serial data into the scan chains |
| latch_o | output | 16 | Hold-stage outputs |
| lfsr_o | output | 16 | LFSR state |
| mode_o | output | 1 | 1 = burst, 0 = freeze |
| pat_strobe_o | output | 1 | Last shift cycle of a pattern |

## Verification
The assertions assume the three codes do not change between reset release and the next reset. They also assume the pattern length is at least two cycles. The stimulus holds to this because it runs each code set as a separate session: it drives new codes only while rst_ni is low and only then releases reset. The sessions cover a bypassed generator, mixed weights, a freeze-locked setup and a burst-locked setup. Each R8 corner is therefore reached from a clean reset.

// File: rtl/lp_pkg.sv
package lp_pkg;
  // Weighted bit: terms are 1 with probability 1/2, 1/4, 1/8, 1/16.
  function automatic logic weigh(input logic [3:0] code, input logic [9:0] b);
    logic [3:0] p;
    p[0] = b[0];
    p[1] = &b[2:1];
    p[2] = &b[5:3];
    p[3] = &b[9:6];
    return |(code & p);
  endfunction
endpackage

// File: rtl/lp_lfsr.sv
module lp_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  logic [W-1:0] s_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) s_q <= SEED;
    else         s_q <= {s_q[W-2:0], ^(s_q & TAPS)};
  assign state_o = s_q;
endmodule

// File: rtl/lp_ctrl.sv
module lp_ctrl
  import lp_pkg::*;
#(
  parameter int W       = 16,
  parameter int PAT_LEN = 32,
  localparam int CW     = $clog2(PAT_LEN)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] prpg_i,
  input  logic [3:0]   sw_code_i,
  input  logic [3:0]   brst_code_i,
  input  logic [3:0]   frz_code_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] ctrl_o,
  output logic         mode_o,
  output logic         strobe_o
);
  logic [W-1:0]  shr_q, ctrl_q;
  logic [CW-1:0] cnt_q;
  logic          mode_q, lp_off, term;
  logic [3:0]    term_code;

  assign strobe_o  = (cnt_q == CW'(PAT_LEN-1));
  assign lp_off    = ~|sw_code_i;
  assign term_code = mode_q ? brst_code_i : frz_code_i;
  assign term      = weigh(term_code, prpg_i[W-1:W-10]);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      shr_q  <= '0;
      ctrl_q <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      shr_q  <= {shr_q[W-2:0], weigh(sw_code_i, prpg_i[9:0])};
      cnt_q  <= strobe_o ? '0 : cnt_q + 1'b1;
      mode_q <= mode_q ^ term;
      if (strobe_o) ctrl_q <= shr_q;
    end

  assign en_o   = lp_off ? '1 : (mode_q ? ctrl_q : '0);
  assign ctrl_o = ctrl_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/lp_hold_bank.sv
module lp_hold_bank #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] held_q;
  for (genvar i = 0; i < W; i++) begin : g_stage
    assign q_o[i] = en_i[i] ? d_i[i] : held_q[i];
  end
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) held_q <= '0;
    else         held_q <= q_o;
endmodule

// File: rtl/lp_phase_shift.sv
module lp_phase_shift #(
  parameter int W      = 16,
  parameter int CHAINS = 4,
  parameter int OFF_A  = 5,
  parameter int OFF_B  = 11
) (
  input  logic [W-1:0]      d_i,
  output logic [CHAINS-1:0] scan_o
);
  for (genvar c = 0; c < CHAINS; c++) begin : g_chain
    localparam int IA = (c + OFF_A) % W;
    localparam int IB = (c + OFF_B) % W;
    assign scan_o[c] = d_i[c] ^ d_i[IA] ^ d_i[IB];
  end
endmodule

// File: rtl/lp_pattern_gen.sv
module lp_pattern_gen #(
  parameter int           W       = 16,
  parameter int           CHAINS  = 4,
  parameter int           PAT_LEN = 32,
  parameter logic [W-1:0] TAPS    = 16'hB400,
  parameter logic [W-1:0] SEED    = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        sw_code_i,
  input  logic [3:0]        brst_code_i,
  input  logic [3:0]        frz_code_i,
  output logic [CHAINS-1:0] scan_o,
  output logic [W-1:0]      latch_o,
  output logic [W-1:0]      lfsr_o,
  output logic              mode_o,
  output logic              pat_strobe_o
);
  logic [W-1:0] prpg_w, en_w, ctrl_w, hold_w;

  lp_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk_i, .rst_ni, .state_o(prpg_w));

  lp_ctrl #(.W(W), .PAT_LEN(PAT_LEN)) u_ctrl (
    .clk_i, .rst_ni, .prpg_i(prpg_w), .sw_code_i, .brst_code_i, .frz_code_i,
    .en_o(en_w), .ctrl_o(ctrl_w), .mode_o, .strobe_o(pat_strobe_o));

  lp_hold_bank #(.W(W)) u_hold (
    .clk_i, .rst_ni, .d_i(prpg_w), .en_i(en_w), .q_o(hold_w));

  lp_phase_shift #(.W(W), .CHAINS(CHAINS)) u_ps (
    .d_i(hold_w), .scan_o);

  assign latch_o = hold_w;
  assign lfsr_o  = prpg_w;
endmodule

// File: rtl/lp_pattern_gen_chk.sv
module lp_pattern_gen_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [3:0]   sw_code_i,
  input logic [3:0]   brst_code_i,
  input logic [W-1:0] latch_o,
  input logic [W-1:0] lfsr_o,
  input logic [W-1:0] ctrl_w,
  input logic         mode_o,
  input logic         pat_strobe_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;

  assert_lfsr_nonzero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_o != '0);
  assert_bypass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_code_i == 4'd0) |-> (latch_o == lfsr_o));
  assert_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !mode_o && sw_code_i != 4'd0) |-> (latch_o == $past(latch_o)));
  assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_strobe_o |=> !pat_strobe_o);
  assert_burst_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brst_code_i == 4'd0 && mode_o) |=> mode_o);
  assert_mask_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pat_strobe_o |=> $stable(ctrl_w));
endmodule

bind lp_pattern_gen lp_pattern_gen_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .sw_code_i, .brst_code_i, .latch_o, .lfsr_o,
  .ctrl_w, .mode_o, .pat_strobe_o);

// File: tb/sim_lp_pattern_gen.sv
`timescale 1ns/1ps
module sim_lp_pattern_gen;
  localparam int L = 32;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [3:0] sw, brst, frz;
  logic [3:0] scan;
  logic [15:0] latch, lfsr;
  logic mode, strobe;

  always #5 clk = ~clk;

  lp_pattern_gen u0 (
    .clk_i(clk), .rst_ni, .sw_code_i(sw), .brst_code_i(brst), .frz_code_i(frz),
    .scan_o(scan), .latch_o(latch), .lfsr_o(lfsr), .mode_o(mode), .pat_strobe_o(strobe));

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  logic [15:0] model;
  logic active = 1'b0;
  bit done = 1'b0;

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Driver: after each edge, push the LFSR value expected at the next sample.
  task automatic step();
    @(posedge clk); #1;
    model = nxt(model);
    exp_q.push_back(model);
  endtask

  // Monitor state
  int k;
  bit prev_ok, seen_burst;
  logic [15:0] prev, mism, chg;
  bit prev_strobe;

  always @(negedge clk) begin
    if (active && exp_q.size() > 0) begin
      logic [15:0] e;
      logic [3:0] es;
      e = exp_q.pop_front();
      k++;
      chk(lfsr == e, "R1", lfsr, e);
      for (int c = 0; c < 4; c++)
        es[c] = latch[c] ^ latch[(c+5)%16] ^ latch[(c+11)%16];
      chk(scan == es, "R6", {12'd0, scan}, {12'd0, es});
      chk(strobe == ((k % L) == L-1), "R7", {15'd0, strobe}, {15'd0, 1'b1 ^ strobe ^ ((k % L) == L-1)});
      if (sw == 4'd0) chk(latch == lfsr, "R3", latch, lfsr);
      if (prev_ok && sw != 4'd0 && !mode) chk(latch == prev, "R4", latch, prev);
      if (prev_ok && mode)
        chk(((latch ^ prev) & (latch ^ lfsr)) == '0, "R5", latch, lfsr);
      if (frz == 4'd0) begin
        chk(!mode, "R8 freeze lock", {15'd0, mode}, 16'd0);
        chk(latch == '0, "R8 frozen latch", latch, 16'd0);
      end
      if (brst == 4'd0) begin
        if (seen_burst) chk(mode, "R8 burst lock", {15'd0, mode}, 16'd1);
        if (mode) seen_burst = 1'b1;
      end
      // R9: per-pattern window, a bit never both mismatches lfsr and changes
      if (prev_strobe || !mode) begin mism = '0; chg = '0; end
      if (mode && prev_ok && sw != 4'd0) begin
        mism |= latch ^ lfsr;
        chg  |= latch ^ prev;
        chk((mism & chg) == '0, "R9", mism & chg, 16'd0);
      end
      prev_strobe = strobe;
      prev = latch;
      prev_ok = 1'b1;
    end
  end

  task automatic session(input logic [3:0] s, input logic [3:0] b, input logic [3:0] f, input int n);
    @(negedge clk);
    rst_ni = 1'b0;
    sw = s; brst = b; frz = f;
    repeat (2) @(negedge clk);
    chk(lfsr == 16'hACE1, "R2 seed", lfsr, 16'hACE1);
    chk(!mode && !strobe, "R2 mode/strobe", {14'd0, mode, strobe}, 16'd0);
    chk(latch == ((s == 4'd0) ? 16'hACE1 : 16'd0), "R2 latch", latch,
        (s == 4'd0) ? 16'hACE1 : 16'd0);
    #1;
    k = 0; prev_ok = 1'b0; seen_burst = 1'b0; prev_strobe = 1'b0;
    mism = '0; chg = '0;
    model = 16'hACE1;
    rst_ni = 1'b1;
    active = 1'b1;
    repeat (n) step();
    @(negedge clk); #1;
    active = 1'b0;
    chk(exp_q.size() == 0, "R1 queue drained", 16'(exp_q.size()), 16'd0);
  endtask

  initial begin
    sw = 4'd0; brst = 4'd0; frz = 4'd0;
    session(4'h0, 4'h3, 4'h3, 200);
    session(4'h5, 4'h2, 4'h4, 400);
    session(4'h8, 4'h1, 4'h0, 200);
    session(4'hF, 4'h0, 4'hF, 400);
    session(4'h3, 4'h1, 4'h1, 300);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule